// File: doc/BRIEF.md
# Exception Priority Sequencing Controller

This controller decides when a simple processor core takes a pending exception, and in what order. It collects requests from five classes: reset, bus error, breakpoint, external interrupts and synchronous traps. It selects the most urgent request that the current phase allows. For every class except reset, it runs a three-word frame push through a valid/ready stack port. It then presents a registered vector number together with a handler-entry flag until the handler's first instruction retires.

While that first instruction is outstanding, only reset, bus error and breakpoint can break in. Interrupts and traps are held off, so the handler can mask interrupts before any of them arrives. A bus error or breakpoint that arrives while a frame is being pushed is taken as soon as the last word of that frame is accepted. The earlier handler is never entered first. A reset request aborts whatever is in progress and pushes nothing. A return-from-exception strobe in the idle phase pops three words, restores the saved state and reports it with a one-cycle pulse.

Top module: `exc_seq_ctrl`

## Requirements
- R1: Slot numbers double as vector numbers, and a lower slot is more urgent. Reset is slot 0, bus error slot 1, breakpoint slot 2, interrupt k slot 3+k and trap k slot 3+N_IRQ+k. The lowest eligible slot is taken, so with N_IRQ=4 and N_TRAP=4, trap 0 is vector 7.
- R2: A reset, bus-error, breakpoint or trap request is a one-cycle pulse that stays pending until it is taken. An interrupt is a level that counts only in cycles where it is high and `irq_mask` is 0; nothing of it is remembered while it is masked. Reset, bus error and breakpoint ignore the mask.
- R3: Accepting a non-reset exception snapshots `cur_status`, `cur_pc` and `cur_aux`. These three words are then pushed in that order, one word per handshake. Each word stays on `push_data` with `push_valid` high until `push_ready` is seen.
- R4: `vec_sel` is registered and is loaded only when an exception is accepted. `handler_entry` rises in the cycle after the last push is accepted. While `handler_entry` is high, `vec_sel` does not change unless a further exception is accepted.
- R5: While `handler_entry` is high, only reset, bus error and breakpoint are accepted; a waiting interrupt or trap is ignored. A `retire` strobe in that phase returns the controller to idle. A waiting interrupt or trap is then accepted at the next edge.
- R6: A bus error or breakpoint that becomes pending during a push sequence is accepted at the edge where the last word is accepted. A new push sequence starts at once, and `handler_entry` never rises for the interrupted exception.
- R7: An eligible reset request is accepted at the next edge from any phase, including mid-push and mid-pop. It pushes nothing, sets `vec_sel` to 0 and raises `handler_entry` in the following cycle.
- R8: When `rti` is seen in the idle phase with no eligible request, three pops follow. They return the auxiliary word, then the program counter, then the status word. `restore_valid` pulses for exactly one cycle after the third pop, with the three restored words on the restore outputs. `rti` is ignored in every other phase.
- R9: While `rst` is high the controller returns to idle with `vec_sel` at 0 and every strobe output low. All pending requests are discarded.
- R10: A request seen at an edge in the idle phase puts `push_valid` high in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rst | input | 1 | Reset exception request pulse |
| req_berr | input | 1 | Bus error request pulse |
| req_brk | input | 1 | Breakpoint request pulse |
| irq | input | N_IRQ | Interrupt request levels |
| irq_mask | input | 1 | 1 blocks all interrupt levels |
| trap | input | N_TRAP | Synchronous trap request pulses |
| retire | input | 1 | Instruction retire strobe |
| rti | input | 1 | Return-from-exception decoded strobe |
| cur_status | input | DW | Status word to save |
| cur_pc | input | DW | Resume address to save |
| cur_aux | input | DW | Auxiliary word to save |
| push_valid | output | 1 | Stack push request |
| push_ready | input | 1 | Stack accepts the pushed word |
| push_data | output | DW | Word being pushed |
| pop_valid | output | 1 | Stack pop request |
| pop_ready | input | 1 | Stack delivers a popped word |
| pop_data | input | DW | Popped word |
| handler_entry | output | 1 | Handler entered, first instruction outstanding |
| vec_sel | output | VW | Vector number of the accepted exception |
| restore_valid | output | 1 | One-cycle pulse: restored frame ready |
| restore_status | output | DW | Restored status word |
| restore_pc | output | DW | Restored resume address |
| restore_aux | output | DW | Restored auxiliary word |

## Verification
Acceptance is due one edge after the request, pushes advance one word per edge with `push_ready` high, and `handler_entry` follows one edge after the third push. After a `retire` edge, a waiting interrupt or trap needs two edges before `push_valid` returns. A reset request shows on `handler_entry` one edge later. `restore_valid` appears one edge after the third pop and is gone at the next. The bench advances its reference model at each rising edge and compares every output at the following falling edge. Each directed check is made after a fixed count of edges from its stimulus, derived from these latencies.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STACK   = 2'd1,
        ST_WINDOW  = 2'd2,
        ST_UNSTACK = 2'd3
    } seq_state_e;

    localparam int unsigned FRAME_WORDS = 3;
    localparam int unsigned HI_CLASS    = 3;
    localparam int unsigned SLOT_RESET  = 0;

    function automatic int unsigned slot_count(int unsigned n_irq, int unsigned n_trap);
        return HI_CLASS + n_irq + n_trap;
    endfunction

endpackage

// File: rtl/exc_pend.sv
module exc_pend
    import exc_seq_pkg::*;
#(
    parameter int unsigned N_IRQ  = 4,
    parameter int unsigned N_TRAP = 4,
    localparam int unsigned NSRC  = slot_count(N_IRQ, N_TRAP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_rst,
    input  logic              req_berr,
    input  logic              req_brk,
    input  logic [N_IRQ-1:0]  irq,
    input  logic              irq_mask,
    input  logic [N_TRAP-1:0] trap,
    input  logic [NSRC-1:0]   clr,
    output logic [NSRC-1:0]   elig
);
    localparam logic [NSRC-1:0] LATCHED = {{N_TRAP{1'b1}}, {N_IRQ{1'b0}}, 3'b111};

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] held_q;

    assign raw  = {trap, irq & {N_IRQ{~irq_mask}}, req_brk, req_berr, req_rst};
    assign elig = (held_q & LATCHED) | raw;

    always_ff @(posedge clk) begin
        if (rst) held_q <= '0;
        else     held_q <= elig & LATCHED & ~clr;
    end
endmodule

// File: rtl/exc_pick.sv
module exc_pick #(
    parameter int unsigned N = 11,
    parameter int unsigned W = 4
) (
    input  logic [N-1:0] cand,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/exc_frame.sv
module exc_frame
    import exc_seq_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] status_in,
    input  logic [DW-1:0] pc_in,
    input  logic [DW-1:0] aux_in,
    input  logic          cnt_clr,
    input  logic          push_step,
    input  logic          pop_step,
    input  logic [DW-1:0] pop_data,
    output logic [DW-1:0] push_data,
    output logic          last_word,
    output logic [DW-1:0] rs_status,
    output logic [DW-1:0] rs_pc,
    output logic [DW-1:0] rs_aux
);
    localparam logic [1:0] LAST = 2'(FRAME_WORDS - 1);

    logic [1:0]    cnt_q;
    logic [DW-1:0] sv_status, sv_pc, sv_aux;

    assign last_word = (cnt_q == LAST);

    always_comb begin
        case (cnt_q)
            2'd0:    push_data = sv_status;
            2'd1:    push_data = sv_pc;
            2'd2:    push_data = sv_aux;
            default: push_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            sv_status <= '0;
            sv_pc     <= '0;
            sv_aux    <= '0;
            rs_status <= '0;
            rs_pc     <= '0;
            rs_aux    <= '0;
        end else begin
            if (load) begin
                sv_status <= status_in;
                sv_pc     <= pc_in;
                sv_aux    <= aux_in;
            end
            if (cnt_clr)
                cnt_q <= '0;
            else if (push_step || pop_step)
                cnt_q <= last_word ? 2'd0 : cnt_q + 2'd1;
            if (pop_step) begin
                case (cnt_q)
                    2'd0:    rs_aux    <= pop_data;
                    2'd1:    rs_pc     <= pop_data;
                    default: rs_status <= pop_data;
                endcase
            end
        end
    end
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
    import exc_seq_pkg::*;
#(
    parameter int unsigned N_IRQ  = 4,
    parameter int unsigned N_TRAP = 4,
    parameter int unsigned DW     = 16,
    localparam int unsigned NSRC  = slot_count(N_IRQ, N_TRAP),
    localparam int unsigned VW    = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_rst,
    input  logic              req_berr,
    input  logic              req_brk,
    input  logic [N_IRQ-1:0]  irq,
    input  logic              irq_mask,
    input  logic [N_TRAP-1:0] trap,
    input  logic              retire,
    input  logic              rti,
    input  logic [DW-1:0]     cur_status,
    input  logic [DW-1:0]     cur_pc,
    input  logic [DW-1:0]     cur_aux,
    output logic              push_valid,
    input  logic              push_ready,
    output logic [DW-1:0]     push_data,
    output logic              pop_valid,
    input  logic              pop_ready,
    input  logic [DW-1:0]     pop_data,
    output logic              handler_entry,
    output logic [VW-1:0]     vec_sel,
    output logic              restore_valid,
    output logic [DW-1:0]     restore_status,
    output logic [DW-1:0]     restore_pc,
    output logic [DW-1:0]     restore_aux
);
    localparam logic [NSRC-1:0] HI_MASK  = NSRC'(3'b111);
    localparam logic [NSRC-1:0] RST_MASK = NSRC'(1);
    localparam logic [VW-1:0]   VEC_RST  = VW'(SLOT_RESET);

    seq_state_e      state_q;
    logic [VW-1:0]   vec_q;
    logic            rv_q;
    logic [NSRC-1:0] elig, allow, cand, clr;
    logic            take;
    logic [VW-1:0]   take_vec;
    logic            last_word;
    logic            push_step, pop_step, cnt_clr, load;

    exc_pend #(.N_IRQ(N_IRQ), .N_TRAP(N_TRAP)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .req_rst  (req_rst),
        .req_berr (req_berr),
        .req_brk  (req_brk),
        .irq      (irq),
        .irq_mask (irq_mask),
        .trap     (trap),
        .clr      (clr),
        .elig     (elig)
    );

    // Which slots the current phase may accept
    always_comb begin
        case (state_q)
            ST_IDLE:   allow = '1;
            ST_WINDOW: allow = HI_MASK;
            ST_STACK:  allow = (push_ready && last_word) ? HI_MASK : RST_MASK;
            default:   allow = RST_MASK;
        endcase
    end

    assign cand = elig & allow;

    exc_pick #(.N(NSRC), .W(VW)) u_pick (
        .cand  (cand),
        .found (take),
        .idx   (take_vec)
    );

    assign clr       = take ? (NSRC'(1) << take_vec) : '0;
    assign load      = take && (take_vec != VEC_RST);
    assign cnt_clr   = take || (state_q == ST_IDLE && rti);
    assign push_step = (state_q == ST_STACK) && push_ready && !take;
    assign pop_step  = (state_q == ST_UNSTACK) && pop_ready && !take;

    exc_frame #(.DW(DW)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .status_in (cur_status),
        .pc_in     (cur_pc),
        .aux_in    (cur_aux),
        .cnt_clr   (cnt_clr),
        .push_step (push_step),
        .pop_step  (pop_step),
        .pop_data  (pop_data),
        .push_data (push_data),
        .last_word (last_word),
        .rs_status (restore_status),
        .rs_pc     (restore_pc),
        .rs_aux    (restore_aux)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
            rv_q    <= 1'b0;
        end else begin
            rv_q <= pop_step && last_word;
            if (take) begin
                vec_q   <= take_vec;
                state_q <= (take_vec == VEC_RST) ? ST_WINDOW : ST_STACK;
            end else begin
                case (state_q)
                    ST_IDLE:    if (rti) state_q <= ST_UNSTACK;
                    ST_STACK:   if (push_ready && last_word) state_q <= ST_WINDOW;
                    ST_WINDOW:  if (retire) state_q <= ST_IDLE;
                    ST_UNSTACK: if (pop_ready && last_word) state_q <= ST_IDLE;
                    default:    state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign push_valid    = (state_q == ST_STACK);
    assign pop_valid     = (state_q == ST_UNSTACK);
    assign handler_entry = (state_q == ST_WINDOW);
    assign vec_sel       = vec_q;
    assign restore_valid = rv_q;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
    parameter int unsigned DW = 16,
    parameter int unsigned VW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          push_valid,
    input logic          push_ready,
    input logic [DW-1:0] push_data,
    input logic          pop_valid,
    input logic          pop_ready,
    input logic          handler_entry,
    input logic [VW-1:0] vec_sel,
    input logic          restore_valid,
    input logic          take,
    input logic [VW-1:0] take_vec,
    input logic          rst_elig
);
    // R3: a word offered and not accepted stays offered, unchanged
    assert_push_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (push_valid && !push_ready && !rst_elig) |=> (push_valid && $stable(push_data)));

    // R4: vector held while the handler's first instruction is outstanding
    assert_vec_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (handler_entry && !take) |=> $stable(vec_sel));

    // R5: from the entry phase no interrupt or trap push can start
    assert_window_block_R5: assert property (@(posedge clk) disable iff (rst)
        handler_entry |=> !(push_valid && vec_sel >= VW'(3)));

    // R7: accepted reset pushes nothing and enters with vector 0
    assert_reset_noframe_R7: assert property (@(posedge clk) disable iff (rst)
        (take && take_vec == '0) |=> (!push_valid && handler_entry && vec_sel == '0));

    // R8: a pop offered and not accepted stays offered
    assert_pop_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (pop_valid && !pop_ready && !rst_elig) |=> pop_valid);

    // R8: restore pulse lasts one cycle
    assert_restore_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        restore_valid |=> !restore_valid);
endmodule

bind exc_seq_ctrl exc_seq_chk #(.DW(DW), .VW(VW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .push_valid    (push_valid),
    .push_ready    (push_ready),
    .push_data     (push_data),
    .pop_valid     (pop_valid),
    .pop_ready     (pop_ready),
    .handler_entry (handler_entry),
    .vec_sel       (vec_sel),
    .restore_valid (restore_valid),
    .take          (take),
    .take_vec      (take_vec),
    .rst_elig      (elig[0])
);

// File: tb/tb_exc_seq_ctrl.sv
module tb_exc_seq_ctrl;
    localparam int NI = 4;
    localparam int NT = 4;
    localparam int DW = 16;
    localparam int NS = 3 + NI + NT;

    logic clk = 0;
    logic rst = 1;
    logic req_rst = 0, req_berr = 0, req_brk = 0;
    logic [NI-1:0] irq = '0;
    logic irq_mask = 0;
    logic [NT-1:0] trap = '0;
    logic retire = 0, rti = 0;
    logic [DW-1:0] cur_status = '0, cur_pc = '0, cur_aux = '0;
    logic push_valid, push_ready = 0;
    logic [DW-1:0] push_data;
    logic pop_valid, pop_ready = 0;
    logic [DW-1:0] pop_data = '0;
    logic handler_entry;
    logic [3:0] vec_sel;
    logic restore_valid;
    logic [DW-1:0] restore_status, restore_pc, restore_aux;

    int nchecks = 0;
    int nerrors = 0;

    always #5 clk = ~clk;

    exc_seq_ctrl #(.N_IRQ(NI), .N_TRAP(NT), .DW(DW)) dut (
        .clk(clk), .rst(rst), .req_rst(req_rst), .req_berr(req_berr), .req_brk(req_brk),
        .irq(irq), .irq_mask(irq_mask), .trap(trap), .retire(retire), .rti(rti),
        .cur_status(cur_status), .cur_pc(cur_pc), .cur_aux(cur_aux),
        .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
        .handler_entry(handler_entry), .vec_sel(vec_sel), .restore_valid(restore_valid),
        .restore_status(restore_status), .restore_pc(restore_pc), .restore_aux(restore_aux)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchecks++;
        if (got !== exp) begin
            nerrors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int mst = 0;           // 0 idle, 1 pushing, 2 entered, 3 popping
    int mcnt = 0;
    int mvec = 0;
    bit mpend [NS];
    logic [DW-1:0] mfr [3];
    logic [DW-1:0] mrs [3];  // status, pc, aux
    bit mrv = 0;

    always @(posedge clk) begin
        bit el [NS];
        int lim, pk;
        bit lastp;
        if (rst) begin
            mst = 0; mcnt = 0; mvec = 0; mrv = 0;
            for (int k = 0; k < NS; k++) mpend[k] = 0;
            for (int k = 0; k < 3; k++) begin mfr[k] = '0; mrs[k] = '0; end
        end else begin
            el[0] = mpend[0] | req_rst;
            el[1] = mpend[1] | req_berr;
            el[2] = mpend[2] | req_brk;
            for (int k = 0; k < NI; k++) el[3+k] = irq[k] & !irq_mask;
            for (int k = 0; k < NT; k++) el[3+NI+k] = mpend[3+NI+k] | trap[k];
            lastp = (mst == 1) && push_ready && (mcnt == 2);
            lim = (mst == 0) ? NS : ((mst == 2 || lastp) ? 3 : 1);
            pk = -1;
            for (int k = lim - 1; k >= 0; k--) if (el[k]) pk = k;
            for (int k = 0; k < NS; k++)
                if (k < 3 || k >= 3 + NI) mpend[k] = el[k] && (k != pk);
            mrv = 0;
            if (pk >= 0) begin
                mvec = pk; mcnt = 0;
                if (pk == 0) mst = 2;
                else begin
                    mst = 1;
                    mfr[0] = cur_status; mfr[1] = cur_pc; mfr[2] = cur_aux;
                end
            end else begin
                case (mst)
                    0: if (rti) begin mst = 3; mcnt = 0; end
                    1: if (push_ready) begin if (mcnt == 2) mst = 2; else mcnt++; end
                    2: if (retire) mst = 0;
                    default: if (pop_ready) begin
                        mrs[2-mcnt] = pop_data;
                        if (mcnt == 2) begin mst = 0; mrv = 1; end else mcnt++;
                    end
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R3 push_valid", push_valid, mst == 1);
            if (mst == 1) chk("R3 push_data", push_data, mfr[mcnt]);
            chk("R8 pop_valid", pop_valid, mst == 3);
            chk("R5 handler_entry", handler_entry, mst == 2);
            chk("R1 vec_sel", vec_sel, mvec);
            chk("R8 restore_valid", restore_valid, mrv);
            chk("R8 restore_status", restore_status, mrs[0]);
            chk("R8 restore_pc", restore_pc, mrs[1]);
            chk("R8 restore_aux", restore_aux, mrs[2]);
        end
    end

    // ---------------- directed and random stimulus ----------------
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enter_and_retire();
        for (int n = 0; n < 20 && !handler_entry; n++) tick();
        retire = 1; tick(); retire = 0;
    endtask

    initial begin
        int exp_order [4];
        exp_order[0] = 2; exp_order[1] = 6; exp_order[2] = 8; exp_order[3] = 10;
        @(negedge clk);
        tick(); tick();
        rst = 0; tick();
        // R9: reset state
        chk("R9 vec_sel", vec_sel, 0);
        chk("R9 handler_entry", handler_entry, 0);
        chk("R9 push_valid", push_valid, 0);
        chk("R9 pop_valid", pop_valid, 0);
        chk("R9 restore_valid", restore_valid, 0);

        // R9: pending trap discarded by reset
        req_berr = 1; tick(); req_berr = 0;
        trap[2] = 1; tick(); trap[2] = 0;
        rst = 1; tick(); rst = 0; tick();
        chk("R9 push_valid after rst", push_valid, 0);
        tick(); tick();
        chk("R9 pending trap discarded", push_valid, 0);

        // R10, R3, R4, R5
        cur_status = 16'h00A1; cur_pc = 16'h00B2; cur_aux = 16'h00C3;
        trap[0] = 1; tick(); trap[0] = 0;
        cur_status = 16'hFFF1; cur_pc = 16'hFFF2; cur_aux = 16'hFFF3;
        chk("R10 push_valid next cycle", push_valid, 1);
        chk("R3 first word status", push_data, 16'h00A1);
        tick();
        chk("R3 word held while not ready", push_data, 16'h00A1);
        push_ready = 1; tick();
        chk("R3 second word pc", push_data, 16'h00B2);
        tick();
        chk("R3 third word aux", push_data, 16'h00C3);
        tick();
        chk("R4 handler_entry", handler_entry, 1);
        chk("R4 vec trap0", vec_sel, 7);
        irq[2] = 1; tick();
        chk("R5 irq blocked in window", push_valid, 0);
        chk("R5 still entered", handler_entry, 1);
        chk("R4 vec held", vec_sel, 7);
        retire = 1; tick(); retire = 0;
        chk("R5 idle after retire", handler_entry, 0);
        tick();
        chk("R5 irq taken after retire", push_valid, 1);
        tick(); tick(); tick();
        chk("R4 vec irq2", vec_sel, 5);
        irq[2] = 0;
        retire = 1; tick(); retire = 0;

        // R2: masking
        irq_mask = 1; irq[0] = 1;
        tick(); tick(); tick();
        chk("R2 masked irq ignored", push_valid, 0);
        req_brk = 1; tick(); req_brk = 0;
        chk("R2 breakpoint ignores mask", push_valid, 1);
        tick(); tick(); tick();
        chk("R2 breakpoint vector", vec_sel, 2);
        retire = 1; tick(); retire = 0;
        tick();
        chk("R2 masked irq still ignored", push_valid, 0);
        irq[0] = 0; irq_mask = 0; tick(); tick();
        chk("R2 irq level not remembered", push_valid, 0);

        // R1: priority among simultaneous requests
        trap[3] = 1; trap[1] = 1; req_brk = 1; irq[3] = 1;
        tick();
        trap = '0; req_brk = 0;
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < 20 && !handler_entry; n++) tick();
            chk("R1 order", vec_sel, exp_order[k]);
            if (exp_order[k] == 6) irq[3] = 0;
            retire = 1; tick(); retire = 0;
        end

        // R6: bus error during pushing
        trap[0] = 1; tick(); trap[0] = 0;
        req_berr = 1; tick(); req_berr = 0;
        tick(); tick();
        chk("R6 no entry for earlier", handler_entry, 0);
        chk("R6 new push sequence", push_valid, 1);
        chk("R6 bus error vector", vec_sel, 1);
        tick(); tick(); tick();
        chk("R6 bus error handler entered", handler_entry, 1);
        retire = 1; tick(); retire = 0;

        // R7: reset mid-push and mid-pop
        push_ready = 0;
        trap[2] = 1; tick(); trap[2] = 0;
        tick();
        req_rst = 1; tick(); req_rst = 0;
        chk("R7 entry after reset mid-push", handler_entry, 1);
        chk("R7 vector 0", vec_sel, 0);
        chk("R7 no push", push_valid, 0);
        retire = 1; tick(); retire = 0;
        pop_ready = 0;
        rti = 1; tick(); rti = 0;
        chk("R8 pop started", pop_valid, 1);
        req_rst = 1; tick(); req_rst = 0;
        chk("R7 pop aborted", pop_valid, 0);
        chk("R7 entry after reset mid-pop", handler_entry, 1);
        chk("R7 no restore", restore_valid, 0);
        retire = 1; tick(); retire = 0;

        // R8: unstack
        pop_ready = 1;
        rti = 1; tick(); rti = 0;
        pop_data = 16'h0111; tick();
        pop_data = 16'h0222; tick();
        pop_data = 16'h0333; tick();
        chk("R8 restore pulse", restore_valid, 1);
        chk("R8 status", restore_status, 16'h0333);
        chk("R8 pc", restore_pc, 16'h0222);
        chk("R8 aux", restore_aux, 16'h0111);
        tick();
        chk("R8 pulse ends", restore_valid, 0);
        push_ready = 1;
        trap[1] = 1; tick(); trap[1] = 0;
        tick(); tick(); tick();
        rti = 1; tick(); rti = 0;
        chk("R8 rti ignored in window", pop_valid, 0);
        chk("R8 window kept", handler_entry, 1);
        retire = 1; tick(); retire = 0;

        // random traffic, compared every cycle against the model
        for (int n = 0; n < 4000; n++) begin
            rst       = ($urandom_range(0, 499) == 0);
            req_rst   = ($urandom_range(0, 63) == 0);
            req_berr  = ($urandom_range(0, 15) == 0);
            req_brk   = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 7) == 0) irq = NI'($urandom);
            if ($urandom_range(0, 31) == 0) irq_mask = ~irq_mask;
            for (int k = 0; k < NT; k++) trap[k] = ($urandom_range(0, 19) == 0);
            retire     = ($urandom_range(0, 2) == 0);
            rti        = ($urandom_range(0, 7) == 0);
            push_ready = ($urandom_range(0, 3) != 0);
            pop_ready  = ($urandom_range(0, 3) != 0);
            pop_data   = DW'($urandom);
            cur_status = DW'($urandom);
            cur_pc     = DW'($urandom);
            cur_aux    = DW'($urandom);
            tick();
        end
        rst = 0;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

    initial begin
        #2000000;
        nchecks++;
        nerrors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end
endmodule